// File: doc/BRIEF.md
# Conversion Cancel and Restart Controller

This block sits beside a converter's sequencing logic. It decides when a running conversion has to be thrown away, when the queued conversions of the channel FIFO have to be discarded with it, and whether a fresh conversion is launched afterwards. It receives one-cycle write strobes for the main control register, the mode register, the FIFO-setup register and the two compare-value registers. It also receives the channel code carried by a control write, the configured FIFO depth, a strobe saying the channel FIFO has been refilled, a stop-mode request, the enable bit of the converter's own asynchronous clock, and a strobe marking the natural end of a conversion.

It answers with four outputs: a one-cycle cancel pulse, a one-cycle queue-flush pulse, a one-cycle start pulse, and a level that is high while a conversion is running. A nonzero FIFO depth selects FIFO mode. A channel code of all ones means the converter is switched off. A control write with an enabled channel restarts at once outside FIFO mode. In FIFO mode the same write arms a restart that fires only when the queue has been refilled to depth.

Top module: `adc_abort_ctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, cancel, flush, start and busy outputs are all low.
- R2: A control, mode, FIFO-setup or compare-value write sampled while busy gives a cancel pulse of exactly one cycle on the next cycle, with busy low in that same cycle; such a write while idle gives no cancel pulse.
- R3: A control write whose channel code is not all ones (5'b11111 with the default width), sampled while the FIFO depth is zero, gives a start pulse one cycle after the cancel slot; busy rises together with that start pulse.
- R4: A control write whose channel code is all ones never leads to a start pulse, and the block stays idle.
- R5: A control write sampled while the FIFO depth is nonzero gives a flush pulse in the cancel slot, and starts nothing by itself.
- R6: After a control write with an enabled channel in FIFO mode, the first sampled refill strobe (with depth still nonzero) gives a start pulse one cycle later, and busy rises with it.
- R7: A mode, FIFO-setup or compare-value write never starts a conversion and cancels a start due on the next cycle. It flushes the queue only when the FIFO depth is nonzero.
- R8: A stop request while the asynchronous clock enable is low cancels a running conversion, a due start and an armed FIFO restart. With the enable high it has no effect.
- R9: The done strobe while busy drops busy on the next cycle without a cancel pulse.
- R10: A refill strobe that no control write has armed is ignored.
- R11: When a cancel cause and the done strobe are sampled together while busy, the cancel pulse is still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ctrl | input | 1 | Write strobe, main control register |
| wr_chan | input | CHAN_W | Channel code carried by the control write |
| wr_mode | input | 1 | Write strobe, mode register |
| wr_fcfg | input | 1 | Write strobe, FIFO-setup register |
| wr_cmp_hi | input | 1 | Write strobe, upper compare value |
| wr_cmp_lo | input | 1 | Write strobe, lower compare value |
| fifo_depth | input | DEPTH_W | Configured queue depth, zero selects single mode |
| fifo_refilled | input | 1 | Channel queue refilled to depth |
| stop_req | input | 1 | Stop-mode entry request |
| async_clk_en | input | 1 | Converter asynchronous clock enabled |
| conv_done | input | 1 | Running conversion finished |
| abort_o | output | 1 | One-cycle cancel pulse |
| flush_o | output | 1 | One-cycle queue-flush pulse |
| start_o | output | 1 | One-cycle start-conversion pulse |
| busy_o | output | 1 | Conversion in progress |

## Verification
The assertions take all inputs as synchronous to the clock and known once reset is released. They treat the strobes as one sample per event, and they let the FIFO depth, the clock enable and the channel code change in any cycle. The stimulus changes inputs only on the falling edge and holds them low during reset. It draws strobes at low rates, with the refill and done strobes more frequent, so that long busy stretches, armed FIFO waits and coincident events all occur.

// File: rtl/adc_abort_ctl.sv
module adc_abort_ctl #(
  parameter int CHAN_W  = 5,
  parameter int DEPTH_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              wr_mode,
  input  logic              wr_fcfg,
  input  logic              wr_cmp_hi,
  input  logic              wr_cmp_lo,
  input  logic [DEPTH_W-1:0] fifo_depth,
  input  logic              fifo_refilled,
  input  logic              stop_req,
  input  logic              async_clk_en,
  input  logic              conv_done,
  output logic              abort_o,
  output logic              flush_o,
  output logic              start_o,
  output logic              busy_o
);

  logic cfg_wr, stop_kill, abort_ev, fifo_mode, chan_off, refill_hit;
  logic pend, armed, pend_n, armed_n, launch;

  assign cfg_wr     = wr_mode | wr_fcfg | wr_cmp_hi | wr_cmp_lo;
  assign stop_kill  = stop_req & ~async_clk_en;
  assign abort_ev   = wr_ctrl | cfg_wr | stop_kill;
  assign fifo_mode  = |fifo_depth;
  assign chan_off   = &wr_chan;
  assign refill_hit = armed & fifo_refilled & fifo_mode;
  assign launch     = pend & ~abort_ev;

  always_comb begin
    pend_n  = 1'b0;
    armed_n = armed;
    if (wr_ctrl) begin
      pend_n  = ~chan_off & ~fifo_mode;
      armed_n = ~chan_off & fifo_mode;
    end else if (stop_kill) begin
      armed_n = 1'b0;
    end else if (cfg_wr) begin
      armed_n = armed;
    end else if (refill_hit) begin
      pend_n  = 1'b1;
      armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abort_o <= 1'b0;
      flush_o <= 1'b0;
      start_o <= 1'b0;
      busy_o  <= 1'b0;
      pend    <= 1'b0;
      armed   <= 1'b0;
    end else begin
      abort_o <= busy_o & abort_ev;
      flush_o <= fifo_mode & (wr_ctrl | cfg_wr);
      start_o <= launch;
      pend    <= pend_n;
      armed   <= armed_n;
      if (abort_ev)       busy_o <= 1'b0;
      else if (launch)    busy_o <= 1'b1;
      else if (conv_done) busy_o <= 1'b0;
    end
  end

  // R2: cancel only ends a running conversion, and lasts one cycle
  a_r2_abort_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!busy_o && $past(busy_o)));
  a_r2_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
  // R3: a start pulse only launches from idle and raises busy
  a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (busy_o && !$past(busy_o)));
  // R4: disabled channel never restarts
  a_r4_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && (&wr_chan)) |=> ##1 !start_o);
  // R5: flush only follows a FIFO-mode write
  a_r5_flush_fifo_only: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> ($past(fifo_depth) != '0));
  // R8: stop with the asynchronous clock running keeps the conversion
  a_r8_stop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && stop_req && async_clk_en && !wr_ctrl && !cfg_wr && !conv_done) |=> busy_o);

endmodule

// File: tb/adc_abort_ctl_bench.sv
module adc_abort_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_ctrl = 0, wr_mode = 0, wr_fcfg = 0, wr_cmp_hi = 0, wr_cmp_lo = 0;
  logic [4:0] wr_chan = '0;
  logic [2:0] fifo_depth = '0;
  logic fifo_refilled = 0, stop_req = 0, async_clk_en = 0, conv_done = 0;
  logic abort_o, flush_o, start_o, busy_o;

  int checks = 0;
  int failures = 0;

  logic m_abort = 0, m_flush = 0, m_start = 0, m_busy = 0, m_pend = 0, m_armed = 0;

  always #2 clk = ~clk;

  adc_abort_ctl u_adc_abort_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_chan(wr_chan),
    .wr_mode(wr_mode), .wr_fcfg(wr_fcfg), .wr_cmp_hi(wr_cmp_hi), .wr_cmp_lo(wr_cmp_lo),
    .fifo_depth(fifo_depth), .fifo_refilled(fifo_refilled), .stop_req(stop_req),
    .async_clk_en(async_clk_en), .conv_done(conv_done),
    .abort_o(abort_o), .flush_o(flush_o), .start_o(start_o), .busy_o(busy_o));

  task automatic chk(input string tag, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, name, act, exp);
    end
  endtask

  function automatic logic is_cfg();
    return wr_mode | wr_fcfg | wr_cmp_hi | wr_cmp_lo;
  endfunction

  task automatic model_step();
    logic any_wr, kill, fifo, off, n_pend, n_armed, go;
    any_wr = wr_ctrl | is_cfg();
    kill   = stop_req & ~async_clk_en;
    fifo   = fifo_depth != 0;
    off    = wr_chan == 5'b11111;
    go     = m_pend & ~(any_wr | kill);
    n_pend = 0; n_armed = m_armed;
    if (wr_ctrl) begin n_pend = !off && !fifo; n_armed = !off && fifo; end
    else if (kill) n_armed = 0;
    else if (is_cfg()) n_armed = m_armed;
    else if (m_armed && fifo_refilled && fifo) begin n_pend = 1; n_armed = 0; end
    m_abort = m_busy & (any_wr | kill);
    m_flush = fifo & any_wr;
    m_start = go;
    if (any_wr | kill) m_busy = 0;
    else if (go) m_busy = 1;
    else if (conv_done) m_busy = 0;
    m_pend = n_pend; m_armed = n_armed;
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "abort_o", abort_o, m_abort);
    chk(tag, "flush_o", flush_o, m_flush);
    chk(tag, "start_o", start_o, m_start);
    chk(tag, "busy_o", busy_o, m_busy);
    wr_ctrl = 0; wr_mode = 0; wr_fcfg = 0; wr_cmp_hi = 0; wr_cmp_lo = 0;
    fifo_refilled = 0; stop_req = 0; conv_done = 0;
  endtask

  task automatic ctrl(input logic [4:0] ch);
    wr_ctrl = 1; wr_chan = ch;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "abort_o", abort_o, 0); chk("R1", "flush_o", flush_o, 0);
    chk("R1", "start_o", start_o, 0); chk("R1", "busy_o", busy_o, 0);
    rst_n = 1;
    tick("R1");
    chk("R1", "busy_o", busy_o, 0);

    // R3 from idle
    ctrl(5'd3); tick("R2"); chk("R2", "abort_o idle", abort_o, 0);
    tick("R3"); chk("R3", "start_o", start_o, 1); chk("R3", "busy_o", busy_o, 1);
    tick("R3"); chk("R3", "start_o end", start_o, 0);
    // R2 and R3 restart while busy
    ctrl(5'd5); tick("R2"); chk("R2", "abort_o", abort_o, 1); chk("R2", "busy_o", busy_o, 0);
    tick("R3"); chk("R3", "restart", start_o, 1); chk("R2", "abort_o single", abort_o, 0);
    // R9
    conv_done = 1; tick("R9"); chk("R9", "busy_o", busy_o, 0); chk("R9", "abort_o", abort_o, 0);
    // R4
    ctrl(5'd1); tick("R3"); tick("R3");
    ctrl(5'b11111); tick("R4"); chk("R4", "abort_o", abort_o, 1);
    tick("R4"); chk("R4", "start_o", start_o, 0);
    tick("R4"); chk("R4", "busy_o", busy_o, 0);
    // R5 and R6
    fifo_depth = 3'd4;
    ctrl(5'd2); tick("R5"); chk("R5", "flush_o", flush_o, 1);
    tick("R5"); chk("R5", "start_o", start_o, 0);
    fifo_refilled = 1; tick("R6"); chk("R6", "start_o early", start_o, 0);
    tick("R6"); chk("R6", "start_o", start_o, 1); chk("R6", "busy_o", busy_o, 1);
    // R7 and R10
    wr_mode = 1; tick("R7"); chk("R7", "abort_o", abort_o, 1); chk("R7", "flush_o", flush_o, 1);
    fifo_refilled = 1; tick("R10"); tick("R10"); chk("R10", "start_o", start_o, 0);
    fifo_depth = 0;
    ctrl(5'd1); tick("R3"); tick("R3");
    wr_cmp_lo = 1; tick("R7"); chk("R7", "flush_o depth0", flush_o, 0);
    chk("R7", "abort_o", abort_o, 1);
    // R7 cancels a due start
    ctrl(5'd6); tick("R7"); wr_fcfg = 1; tick("R7"); chk("R7", "start cancelled", start_o, 0);
    // R8
    ctrl(5'd1); tick("R3"); tick("R3");
    async_clk_en = 1; stop_req = 1; tick("R8"); chk("R8", "busy kept", busy_o, 1);
    async_clk_en = 0; stop_req = 1; tick("R8"); chk("R8", "abort_o", abort_o, 1);
    // R8 cancels armed FIFO restart
    fifo_depth = 3'd2; ctrl(5'd4); tick("R8");
    stop_req = 1; tick("R8"); fifo_refilled = 1; tick("R8"); tick("R8");
    chk("R8", "armed cleared", start_o, 0);
    // R11
    fifo_depth = 0; ctrl(5'd1); tick("R3"); tick("R3");
    conv_done = 1; wr_fcfg = 1; tick("R11"); chk("R11", "abort_o", abort_o, 1);

    // random phase, model-checked
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      wr_ctrl   = ($urandom % 10) == 0;
      wr_chan   = (($urandom % 4) == 0) ? 5'b11111 : 5'($urandom);
      wr_mode   = ($urandom % 30) == 0;
      wr_fcfg   = ($urandom % 30) == 0;
      wr_cmp_hi = ($urandom % 30) == 0;
      wr_cmp_lo = ($urandom % 30) == 0;
      if (($urandom % 20) == 0) fifo_depth = (($urandom % 2) == 0) ? 3'd0 : 3'($urandom);
      fifo_refilled = ($urandom % 4) == 0;
      stop_req  = ($urandom % 12) == 0;
      async_clk_en = ($urandom % 2) == 0;
      conv_done = ($urandom % 6) == 0;
      tick("R2");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule